// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block is a state machine that powers up six supply groups on a module in a fixed order. It drives one enable at a time and waits for that group's power-good input before it enables the next one. The order is pre-regulator, group 1, group 2, core/processor, ADC, DAC. After the last group reports good, a parameterised delay runs. The machine then releases the active-low power-on reset to the processor and enters a ready state. The carrier power-good output goes high in that same ready state, so it tracks the whole sequence and not any one rail.

A power-good that has been confirmed can later drop, in any state including ready. A power-good can also fail to arrive within the timeout. Either event sends the machine to an error path. On that path it removes the enables in reverse order, one rail per power-down step, and then holds every rail off for a hold-off period. After that it starts again from the all-off state. A 3-bit state code shows where the machine is. An active-low reset returns it to the all-off state at once.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, `en_o` is all zero, `por_n_o` and `carrier_pg_o` are low and `state_o` is 0. Asserting `rst_n` in the middle of a sequence clears them at once.
- R2: Enables rise one at a time in bit order 0 to 5. Bit i (i > 0) rises only on a clock edge at which `pg_i[i-1]` is high.
- R3: `state_o` encodes the machine state: 0 = off, 1 = waiting on rail 0 or 1, 2 = waiting on rail 2 or 3, 3 = waiting on rail 4 or 5, 4 = reset-release delay, 5 = ready, 6 = ordered power-down, 7 = hold-off.
- R4: If the power-good of the rail being waited on is still low TIMEOUT_CYC clock cycles after its enable rose, `state_o` becomes 6.
- R5: `por_n_o` goes high exactly POR_DLY+1 clock edges after the edge at which `pg_i[5]` first goes high.
- R6: `por_n_o` and `carrier_pg_o` are high only while `state_o` is 5. Both go low on the same edge on which the ready state is left.
- R7: If a rail's power-good has been confirmed and then goes low in states 1 to 5, `state_o` becomes 6 on the next clock edge.
- R8: During power-down the highest enabled rail is cleared every DOWN_DLY cycles. The first rail is cleared DOWN_DLY cycles after the machine enters state 6, and no enable rises during power-down.
- R9: After the last enable is cleared, the machine stays in state 7 with every rail off for HOLD_CYC cycles. It then shows state 0, and `en_o[0]` rises one cycle later.
- R10: A power-good input of a rail that is not yet confirmed has no effect: an early-high good on a later rail neither advances the sequence nor causes a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_i | input | N_RAILS | Power-good per rail group, bit 0 = pre-regulator ... bit 5 = DAC |
| en_o | output | N_RAILS | Rail enables, same bit order |
| por_n_o | output | 1 | Active-low power-on reset to the processor |
| carrier_pg_o | output | 1 | Carrier power-good, high once the sequence is complete |
| state_o | output | 3 | State code (see R3) |

## Verification
The hardest situations to reach are a fault that hits only after the machine has settled in ready, and a timeout on a rail deep in the chain. The first is followed by the full reverse power-down and the restart. The second must leave exactly the enables of the earlier rails to be removed. The bench models each rail as a power-good that follows its enable after a fixed latency. It can force any rail's good low or high at will. Forcing rail 2 low while in ready, or pinning one rail low before reset, walks the machine into each error path. The bench then times every enable drop against the parameters.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAIT = 3'd1,
    ST_POR  = 3'd2,
    ST_RDY  = 3'd3,
    ST_DOWN = 3'd4,
    ST_HOLD = 3'd5
  } seq_st_e;

  localparam logic [2:0] CODE_OFF  = 3'd0;
  localparam logic [2:0] CODE_POR  = 3'd4;
  localparam logic [2:0] CODE_RDY  = 3'd5;
  localparam logic [2:0] CODE_DOWN = 3'd6;
  localparam logic [2:0] CODE_HOLD = 3'd7;

  // Two consecutive rails share one visible step code.
  function automatic logic [2:0] step_code(input int unsigned idx);
    if (idx >= 4) return 3'd3;
    else if (idx >= 2) return 3'd2;
    else return 3'd1;
  endfunction

  // Index of the highest set bit (0 when the mask is empty).
  function automatic int unsigned top_rail(input logic [31:0] mask);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (mask[i]) r = i;
    end
    return r;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (cnt_q != {CW{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/rail_seq_guard.sv
module rail_seq_guard #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] pg_i,
  input  logic [N-1:0] conf_i,
  input  logic         armed_i,
  output logic         fault_o
);
  logic [N-1:0] lost;

  for (genvar g = 0; g < N; g++) begin : g_lost
    assign lost[g] = conf_i[g] & ~pg_i[g];
  end

  assign fault_o = armed_i & (|lost);
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int unsigned N_RAILS     = 6,
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned POR_DLY     = 200,
  parameter int unsigned DOWN_DLY    = 50,
  parameter int unsigned HOLD_CYC    = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] pg_i,
  output logic [N_RAILS-1:0] en_o,
  output logic               por_n_o,
  output logic               carrier_pg_o,
  output logic [2:0]         state_o
);
  localparam int unsigned CNT_MAX = max2(max2(TIMEOUT_CYC, POR_DLY), max2(DOWN_DLY, HOLD_CYC));
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam int unsigned IW      = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam logic [N_RAILS-1:0] ONE = N_RAILS'(1);

  seq_st_e            st_q, st_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [N_RAILS-1:0] en_q, en_d, conf_q, conf_d, en_less;
  logic [CW-1:0]      lim;
  logic               tmr_clr, tmr_hit, armed, cur_pg, last_step;

  // Named internal events, observed by the checker.
  logic fault_evt, step_done, tmo_evt, down_step;

  assign armed     = (st_q == ST_WAIT) || (st_q == ST_POR) || (st_q == ST_RDY);
  assign cur_pg    = pg_i[idx_q];
  assign last_step = (idx_q == IW'(N_RAILS - 1));
  assign step_done = (st_q == ST_WAIT) && cur_pg && !fault_evt;
  assign tmo_evt   = (st_q == ST_WAIT) && !cur_pg && tmr_hit && !fault_evt;
  assign down_step = (st_q == ST_DOWN) && tmr_hit;
  assign en_less   = en_q & ~(ONE << top_rail(32'(en_q)));

  rail_seq_guard #(.N(N_RAILS)) u_guard (
    .pg_i    (pg_i),
    .conf_i  (conf_q),
    .armed_i (armed),
    .fault_o (fault_evt)
  );

  always_comb begin
    case (st_q)
      ST_WAIT: lim = CW'(TIMEOUT_CYC);
      ST_POR:  lim = CW'(POR_DLY);
      ST_DOWN: lim = CW'(DOWN_DLY);
      ST_HOLD: lim = CW'(HOLD_CYC);
      default: lim = CW'(1);
    endcase
  end

  rail_seq_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .limit_i (lim),
    .hit_o   (tmr_hit)
  );

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    en_d   = en_q;
    conf_d = conf_q;
    case (st_q)
      ST_OFF: begin
        st_d   = ST_WAIT;
        idx_d  = '0;
        en_d   = ONE;
        conf_d = '0;
      end
      ST_WAIT: begin
        if (fault_evt || tmo_evt) begin
          st_d   = ST_DOWN;
          conf_d = '0;
        end else if (step_done) begin
          conf_d = conf_q | (ONE << idx_q);
          if (last_step) begin
            st_d = ST_POR;
          end else begin
            idx_d = idx_q + 1'b1;
            en_d  = en_q | (ONE << (idx_q + 1'b1));
          end
        end
      end
      ST_POR: begin
        if (fault_evt) begin
          st_d   = ST_DOWN;
          conf_d = '0;
        end else if (tmr_hit) begin
          st_d = ST_RDY;
        end
      end
      ST_RDY: begin
        if (fault_evt) begin
          st_d   = ST_DOWN;
          conf_d = '0;
        end
      end
      ST_DOWN: begin
        if (en_q == '0) begin
          st_d = ST_HOLD;
        end else if (down_step) begin
          en_d = en_less;
          if (en_less == '0) st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        en_d = '0;
        if (tmr_hit) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  assign tmr_clr = (st_d != st_q) || down_step || step_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      idx_q  <= '0;
      en_q   <= '0;
      conf_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      en_q   <= en_d;
      conf_q <= conf_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_WAIT: state_o = step_code(32'(idx_q));
      ST_POR:  state_o = CODE_POR;
      ST_RDY:  state_o = CODE_RDY;
      ST_DOWN: state_o = CODE_DOWN;
      ST_HOLD: state_o = CODE_HOLD;
      default: state_o = CODE_OFF;
    endcase
  end

  assign en_o         = en_q;
  assign por_n_o      = (st_q == ST_RDY);
  assign carrier_pg_o = (st_q == ST_RDY);
endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
  parameter int unsigned N_RAILS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_RAILS-1:0] pg_i,
  input logic [N_RAILS-1:0] en_o,
  input logic               por_n_o,
  input logic               carrier_pg_o,
  input logic [2:0]         state_o,
  input logic               fault_evt,
  input logic               tmo_evt
);
  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_o & ~$past(en_o)) <= 1);

  p_rise_after_pg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (((en_o & ~$past(en_o)) >> 1) & ~$past(pg_i)) == '0);

  p_timeout_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (state_o == 3'd6));

  p_por_from_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n_o) |-> ($past(state_o) == 3'd4));

  p_carrier_all_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_pg_o |-> (&$past(pg_i)));

  p_loss_to_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (state_o == 3'd6));

  p_down_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd6) && ($past(state_o) == 3'd6)) |-> ((en_o & ~$past(en_o)) == '0));

  p_hold_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd7) |-> (en_o == '0));
endmodule

bind rail_sequencer rail_sequencer_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pg_i         (pg_i),
  .en_o         (en_o),
  .por_n_o      (por_n_o),
  .carrier_pg_o (carrier_pg_o),
  .state_o      (state_o),
  .fault_evt    (fault_evt),
  .tmo_evt      (tmo_evt)
);

// File: tb/rail_sequencer_bench.sv
`timescale 1ns/1ps
module rail_sequencer_bench;
  localparam int TO  = 20;
  localparam int PD  = 8;
  localparam int DD  = 4;
  localparam int HD  = 16;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pg, en, kill = '0, force_hi = '0;
  logic       por_n, cpg;
  logic [2:0] code;
  logic [LAT-1:0] sh [6];
  int checks = 0, errors = 0, r2_bad = 0;
  logic [5:0] pen = '0, ppg = '0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.N_RAILS(6), .TIMEOUT_CYC(TO), .POR_DLY(PD),
                   .DOWN_DLY(DD), .HOLD_CYC(HD)) u_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .pg_i(pg), .en_o(en),
    .por_n_o(por_n), .carrier_pg_o(cpg), .state_o(code));

  // Rail model: good follows enable after LAT clocks, with overrides.
  always_ff @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 6; i++) begin
      if (!rst_n) sh[i] <= '0;
      else sh[i] <= {sh[i][LAT-2:0], en[i]};
    end
  end
  always_comb begin
    for (int i = 0; i < 6; i++) pg[i] = (sh[i][LAT-1] | force_hi[i]) & ~kill[i];
  end

  // R2 monitor: one rise at a time, each after the previous good.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 1; i < 6; i++) if (en[i] && !pen[i] && !ppg[i-1]) r2_bad++;
      if ($countones(en & ~pen) > 1) r2_bad++;
    end
    pen = en;
    ppg = pg;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic watch_down(input int top);
    for (int k = top; k >= 0; k--) begin
      int n = 0;
      do begin @(negedge clk); n++; end while (en[k] && n < 500);
      chk("R8 drop spacing", n, DD);
      chk("R8 remaining enables", int'(en), (1 << k) - 1);
    end
    chk("R3 hold code", int'(code), 7);
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (code != 3'd0 && n < 500);
      chk("R9 hold length", n, HD);
      chk("R9 all off at restart", int'(en), 0);
      @(negedge clk);
      chk("R9 rail 0 re-enabled", int'(en), 1);
      chk("R3 restart code", int'(code), 1);
    end
  endtask

  typedef struct packed {
    logic [2:0] rail;
    logic [5:0] mask;
    logic [2:0] code;
  } tv_t;
  localparam tv_t TV [3] = '{
    '{rail: 3'd0, mask: 6'h01, code: 3'd1},
    '{rail: 3'd2, mask: 6'h07, code: 3'd2},
    '{rail: 3'd5, mask: 6'h3F, code: 3'd3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t5, tp, cyc, n;
    logic seen5, seen3, seen0f;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 en in reset", int'(en), 0);
    chk("R1 por_n in reset", int'(por_n), 0);
    chk("R1 carrier in reset", int'(cpg), 0);
    chk("R1 code in reset", int'(code), 0);

    // Full bring-up: R3 codes, R5 delay, R6 outputs
    rst_n = 1'b1;
    t5 = -1; tp = -1; cyc = 0; seen5 = 0; seen3 = 0; seen0f = 0;
    while (code != 3'd5 && cyc < 1000) begin
      @(negedge clk); cyc++;
      if (en == 6'h03 && !seen3) begin seen3 = 1; chk("R3 code rail1", int'(code), 1); end
      if (en == 6'h0F && !seen0f) begin seen0f = 1; chk("R3 code rail3", int'(code), 2); end
      if (pg[5] && !seen5) begin
        seen5 = 1; t5 = cyc;
        chk("R3 code rail5", int'(code), 3);
      end
      if (por_n && tp < 0) tp = cyc;
      if (seen5 && cyc == t5 + 1) chk("R3 delay code", int'(code), 4);
    end
    chk("R5 reset release delay", tp - t5, PD + 1);
    chk("R6 carrier in ready", int'(cpg), 1);
    chk("R6 por_n in ready", int'(por_n), 1);
    chk("R2 all enabled", int'(en), 63);

    // R7: confirmed good lost in ready
    repeat (5) @(negedge clk);
    kill[2] = 1'b1;
    @(negedge clk);
    chk("R7 error after loss", int'(code), 6);
    chk("R6 por_n dropped", int'(por_n), 0);
    chk("R6 carrier dropped", int'(cpg), 0);
    watch_down(5);
    kill = '0;

    // R4 timeouts walked from the vector table
    for (int v = 0; v < 3; v++) begin
      kill = '0;
      kill[TV[v].rail] = 1'b1;
      do_reset();
      n = 0;
      while (!en[TV[v].rail] && n < 1000) begin @(negedge clk); n++; end
      chk("R3 waiting code", int'(code), int'(TV[v].code));
      n = 0;
      do begin @(negedge clk); n++; end while (code != 3'd6 && n < 500);
      chk("R4 timeout length", n, TO);
      chk("R4 enables at timeout", int'(en), int'(TV[v].mask));
      watch_down(int'(TV[v].rail));
    end
    kill = '0;

    // R10: early goods on later rails are ignored
    force_hi = 6'h3E;
    do_reset();
    @(negedge clk);
    chk("R10 only rail 0", int'(en), 1);
    repeat (LAT - 1) @(negedge clk);
    force_hi[4] = 1'b0;
    @(negedge clk);
    chk("R10 still waiting rail 0", int'(en), 1);
    chk("R10 no fault", int'(code), 1);
    force_hi = '0;

    // R1: reset mid-sequence
    n = 0;
    while (en != 6'h07 && n < 1000) begin @(negedge clk); n++; end
    rst_n = 1'b0;
    #1;
    chk("R1 async clear en", int'(en), 0);
    chk("R1 async clear code", int'(code), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chk("R2 ordering monitor", r2_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule